// File: doc/BRIEF.md
# Eight-pin GPIO controller with edge interrupts

This block controls eight general-purpose pins through a small register bus. Each pin can serve as an output, which drives a value held in a register and can also have its driver turned off, or as an input. An input pin's value passes through a synchronizer and an optional inversion, and software reads the result. The block drives a pad output value and an output enable for each pin, and it takes the pad input value. Pad cells and tri-state buffers are outside the block.

An input pin whose interrupt is enabled latches a pending event when its value, after inversion, goes from inactive to active. This makes the inversion bit the polarity select. All pending events are ORed onto one interrupt line. A read of the level register clears every pending event. If a new edge lands in the same cycle as that read, the edge is kept.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, all five registers read 0x00, `pad_oe_o` and `pad_out_o` are 0, and `irq_o` is 0.
- R2: Register addresses are: direction 0, level 1, tri-state 2, inversion 3, interrupt enable 4. Direction bit n = 1 makes pin n an output. The direction, tri-state, inversion and enable registers read back the value last written to them.
- R3: `pad_out_o` equals the value last written to the level register.
- R4: `pad_oe_o[n]` is 1 only when pin n is an output and its tri-state bit is 0. A tri-state bit of 1 turns the driver off.
- R5: A level-register read returns the latched drive value for output pins. For input pins it returns the synchronized pad value XOR the inversion bit. A pad change is visible in this read two clock edges after it occurs.
- R6: An inversion bit of 1 inverts that pin's input before status reporting and before edge detection.
- R7: A 0-to-1 transition of the post-inversion value on an input pin with its enable bit set sets that pin's pending bit. `irq_o` goes high three clock edges after the pad change. `irq_o` is the OR of all pending bits.
- R8: An edge on a pin whose enable bit is 0, or on a pin configured as an output, sets no pending bit.
- R9: Reading the level register (address 1, write flag 0) clears all pending bits at that clock edge.
- R10: If a qualifying edge is detected in the same cycle as a level-register read, that pin's pending bit stays set.
- R11: A pending bit stays set until a level-register read, even if the input returns to its inactive value.
- R12: Read data appears on `rdata_o` at the clock edge that samples the read strobe and holds until the next read. Addresses 5 to 7 read as 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pad_in_i | input | 8 | Pad input values |
| pad_out_o | output | 8 | Pad drive values |
| pad_oe_o | output | 8 | Pad output enables, 1 = driving |
| irq_o | output | 1 | Combined interrupt |

## Verification
Edge capture and the read that clears pending events can happen in the same cycle. To provoke this, the bench changes a pad and places a level-register read strobe on exactly the clock edge where the synchronized, inverted value first shows the rise. The collision is judged correct when `irq_o` is still high after that read, while a read on any other cycle leaves it low.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR   = 3'd0,
    REG_LEVEL = 3'd1,
    REG_TRI   = 3'd2,
    REG_INV   = 3'd3,
    REG_IEN   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] inv_i,
  input  logic [W-1:0] arm_i,
  input  logic         clr_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] act, prev_q, rise, pend_q, pend_d;

  assign act  = lvl_i ^ inv_i;
  assign rise = act & ~prev_q;

  // set has priority over the read-clear so a colliding edge survives
  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = '0;
    pend_d = pend_d | (rise & arm_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= act;
      pend_q <= pend_d;
    end
  end

  assign status_o = act;
  assign pend_o   = pend_q;
  assign irq_o    = |pend_q;

  // R8
  pend_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(arm_i)) == '0));

  // R9
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((pend_q & ~$past(rise & arm_i)) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ((rise & arm_i) != '0)) |=>
      ((pend_q & $past(rise & arm_i)) == $past(rise & arm_i)));

  // R11
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(pend_q) & ~pend_q) == '0));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_edge_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      status_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      drive_o,
  output logic [W-1:0]      tri_o,
  output logic [W-1:0]      inv_o,
  output logic [W-1:0]      ien_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] dir_q, drive_q, tri_q, inv_q, ien_q, rdata_q, rmux;
  logic         wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      drive_q <= '0;
      tri_q   <= '0;
      inv_q   <= '0;
      ien_q   <= '0;
    end else if (wr) begin
      case (reg_addr_e'(addr_i))
        REG_DIR:   dir_q   <= wdata_i;
        REG_LEVEL: drive_q <= wdata_i;
        REG_TRI:   tri_q   <= wdata_i;
        REG_INV:   inv_q   <= wdata_i;
        REG_IEN:   ien_q   <= wdata_i;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      REG_DIR:   rmux = dir_q;
      REG_LEVEL: rmux = (dir_q & drive_q) | (~dir_q & status_i);
      REG_TRI:   rmux = tri_q;
      REG_INV:   rmux = inv_q;
      REG_IEN:   rmux = ien_q;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rmux;
  end

  assign dir_o   = dir_q;
  assign drive_o = drive_q;
  assign tri_o   = tri_q;
  assign inv_o   = inv_q;
  assign ien_o   = ien_q;
  assign rdata_o = rdata_q;

  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] dir, drive, tri_en, inv, ien, sync_in, status, pend;
  logic                clr;

  assign clr = req_i & ~we_i & (addr_i == REG_LEVEL);

  gpio_regfile #(.W(NUM_PINS)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .status_i(status),
    .dir_o(dir), .drive_o(drive), .tri_o(tri_en), .inv_o(inv), .ien_o(ien),
    .rdata_o
  );

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(sync_in)
  );

  gpio_edge_irq #(.W(NUM_PINS)) u_irq (
    .clk_i, .rst_ni,
    .lvl_i(sync_in), .inv_i(inv), .arm_i(ien & ~dir), .clr_i(clr),
    .status_o(status), .pend_o(pend), .irq_o
  );

  assign pad_out_o = drive;
  assign pad_oe_o  = dir & ~tri_en;

  // R7
  irq_has_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ien & ~dir) != '0);
endmodule

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;
  logic       irq;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  // {addr, wdata, expected readback}
  localparam logic [18:0] VEC [11] = '{
    {3'd0, 8'h3C, 8'h3C}, {3'd2, 8'h81, 8'h81}, {3'd3, 8'h66, 8'h66},
    {3'd4, 8'hFF, 8'hFF}, {3'd5, 8'h12, 8'h00}, {3'd6, 8'hA7, 8'h00},
    {3'd7, 8'hFF, 8'h00}, {3'd4, 8'h00, 8'h00}, {3'd3, 8'h00, 8'h00},
    {3'd2, 8'h00, 8'h00}, {3'd0, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd, held;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    for (int a = 0; a < 5; a++) begin
      bus_rd(3'(a), rd);
      check("R1 reg reset", rd, 8'h00);
    end

    // R2 R12 register readback table
    for (int i = 0; i < 11; i++) begin
      bus_wr(VEC[i][18:16], VEC[i][15:8]);
      bus_rd(VEC[i][18:16], rd);
      check("R2/R12 readback", rd, VEC[i][7:0]);
    end
    bus_rd(3'd1, rd);
    check("R8 no pending after table", {7'b0, irq}, 8'h00);

    // R3 R4 output drive and enables
    bus_wr(3'd0, 8'hF0);
    bus_wr(3'd1, 8'hA5);
    bus_wr(3'd2, 8'h30);
    check("R3 pad_out", pad_out, 8'hA5);
    check("R4 pad_oe", pad_oe, 8'hC0);

    // R5 mixed level read
    pad_in = 8'h5A;
    idle(3);
    bus_rd(3'd1, rd);
    check("R5 level mixed", rd, 8'hAA);

    // R6 inversion of status
    bus_wr(3'd3, 8'h0F);
    idle(3);
    bus_rd(3'd1, rd);
    check("R6 level inverted", rd, 8'hA5);

    // back to all inputs, no inversion
    bus_wr(3'd3, 8'h00);
    bus_wr(3'd2, 8'h00);
    bus_wr(3'd0, 8'h00);
    pad_in = 8'h00;
    idle(4);
    bus_rd(3'd1, rd);
    check("R5 inputs low", rd, 8'h00);

    // R7 edge latency and irq
    bus_wr(3'd4, 8'h01);
    pad_in = 8'h01;
    idle(2);
    check("R7 irq not yet", {7'b0, irq}, 8'h00);
    idle(1);
    check("R7 irq raised", {7'b0, irq}, 8'h01);

    // R11 sticky
    pad_in = 8'h00;
    idle(5);
    check("R11 sticky", {7'b0, irq}, 8'h01);

    // R9 read clears
    bus_rd(3'd1, rd);
    check("R9 cleared", {7'b0, irq}, 8'h00);

    // R8 disabled pin
    pad_in = 8'h02;
    idle(5);
    check("R8 disabled pin", {7'b0, irq}, 8'h00);
    // R8 output pin with enable set
    bus_wr(3'd0, 8'h04);
    bus_wr(3'd4, 8'h05);
    pad_in = 8'h06;
    idle(5);
    check("R8 output pin", {7'b0, irq}, 8'h00);
    bus_wr(3'd4, 8'h01);
    bus_wr(3'd0, 8'h00);
    pad_in = 8'h00;
    idle(4);
    bus_rd(3'd1, rd);

    // R6 inversion selects falling pad edge (pad0 low -> active)
    bus_wr(3'd4, 8'h00);
    bus_wr(3'd3, 8'h01);
    idle(4);
    bus_rd(3'd1, rd);
    bus_wr(3'd4, 8'h01);
    pad_in = 8'h01;
    idle(5);
    check("R6 rising pad ignored when inverted", {7'b0, irq}, 8'h00);
    pad_in = 8'h00;
    idle(4);
    check("R6 falling pad fires when inverted", {7'b0, irq}, 8'h01);

    // R10 edge and read in the same cycle
    pad_in = 8'h01;
    idle(4);
    bus_rd(3'd1, rd);
    check("R9 clear before collision", {7'b0, irq}, 8'h00);
    @(negedge clk); pad_in = 8'h00;
    @(negedge clk);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = 3'd1;
    @(negedge clk); req = 1'b0;
    check("R10 set wins over clear", {7'b0, irq}, 8'h01);
    bus_rd(3'd1, rd);
    check("R9 clear after collision", {7'b0, irq}, 8'h00);

    // R12 hold between reads, writes leave rdata alone
    bus_rd(3'd4, held);
    check("R12 read ien", held, 8'h01);
    bus_wr(3'd5, 8'h77);
    bus_wr(3'd2, 8'h0F);
    idle(3);
    check("R12 rdata held", rdata, 8'h01);
    bus_rd(3'd5, rd);
    check("R12 unmapped reads zero", rd, 8'h00);

    finish_run();
  end
endmodule